// File: doc/BRIEF.md
# External Bus Cycle Controller

This block turns single requests from an on-chip requester into complete external memory bus cycles. A request carries a 23-bit byte address, 16 bits of write data, two byte enables, a direction bit and a configuration word. The configuration word is normally supplied by a chip-select decoder. The controller captures the configuration word together with the request, so every access can have its own bus shape.

The word selects one of four bus modes. The address and data either share the 16-bit data port or use separate ports, and the external data path is either 8 or 16 bits wide. The word also sets the number of upper address lines, the length of the address-latch pulse, an optional delay before the strobe, the number of wait states, external ready stretching, and a recovery time after reads. In 8-bit mode a full-word access becomes two back-to-back byte cycles. The read result is assembled before the single completion pulse.

Configuration word fields: bit 0 selects multiplexed mode (1) or demultiplexed mode (0). Bit 1 selects 8-bit data (1). Bits 3:2 select the address width. Bit 4 selects the long latch pulse. Bit 5 enables the strobe delay. Bit 6 enables the ready input. Bits 10:7 hold the wait states. Bits 12:11 hold the recovery clocks.

Top module: `ext_bus_cycler`

## Requirements
- R1: `req_ready` is high only while no cycle is in progress. Each accepted request gives exactly one one-clock `rsp_valid` pulse, after all of its bus activity has ended.
- R2: Multiplexed mode (cfg bit 0 = 1): the address appears on `ad_out`, with `ad_oe` high, while `ale` is high, and `addr_lo` is 0. Demultiplexed mode (cfg bit 0 = 0): the address is on `addr_lo` for the whole cycle.
- R3: 16-bit mode (cfg bit 1 = 0) moves data over all of `ad_out`/`ad_in`. 8-bit mode (cfg bit 1 = 1) uses only bits 7:0, with `ad_out[15:8]` = 0 and `ad_in[15:8]` ignored.
- R4: cfg bits 3:2 = 0, 1, 2, 3 give a 16-, 18-, 20- or 23-bit address. `addr_hi` then carries 0, 2, 4 or 7 address bits above bit 15, and the remaining lines stay 0.
- R5: `ale` stays high for 1 clock per bus cycle, or for 2 clocks when cfg bit 4 = 1.
- R6: When cfg bit 5 = 1, one clock with no latch pulse and no strobe is inserted between the latch phase and the strobe.
- R7: A strobe (`rd_n` or `wr_n` low) lasts at least W+1 clocks, where W is cfg bits 10:7.
- R8: When cfg bit 6 = 1, the strobe also continues until `ext_ready` is sampled high on a clock after the wait states. When the bit is 0, `ext_ready` is ignored.
- R9: After a read strobe, T idle clocks follow (T = cfg bits 12:11) before the next latch pulse or completion. No recovery clocks follow a write.
- R10: In 8-bit mode the byte enables (bit 0 = low byte, bit 1 = high byte) select the bytes to transfer. Enables 11 or 00 run two cycles, low byte first at the even address, then the odd address. 01 runs only the even byte and 10 only the odd byte.
- R11: Read data is taken on the last strobe clock. In 8-bit mode each byte lands in its lane of `rsp_rdata`, and lanes that are not read return 0. The result is valid while `rsp_valid` is high.
- R12: During a write, `ad_oe` is high and `ad_out` holds the write data, stable for the whole strobe. During a read strobe, `ad_oe` is low. Read and write strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_addr | input | 23 | Byte address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cfg | input | 13 | Per-access bus configuration word |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 16 | Assembled read data |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_lo | output | 16 | Dedicated low address port (demultiplexed modes) |
| addr_hi | output | 7 | Upper address segment |
| ad_out | output | 16 | Data/address port output value |
| ad_oe | output | 1 | Data/address port drive enable |
| ad_in | input | 16 | Data/address port input value |
| ext_ready | input | 1 | External ready |

## Verification
The assertions check these rules on every clock:
- strobes never overlap;
- the data port is never driven during a read strobe;
- write data holds still while the write strobe is low;
- the latch pulse never exceeds two clocks and never overlaps a strobe;
- the completion pulse is one clock wide;
- the idle indication excludes any bus activity.

Other behaviour needs the bench's sweep of every mode, address width, timing setting, direction and byte-enable pattern against a modelled memory. This covers the exact clock counts of each phase, the masking of the upper address lines, byte ordering, lane assembly, ready stretching, and the fact that a ready input is ignored when disabled.

// File: rtl/ext_bus_cycler.sv
module ext_bus_cycler #(
  parameter int WAIT_W = 4,
  parameter int TRI_W  = 2,
  localparam int CFG_W = 7 + WAIT_W + TRI_W,
  localparam int CW    = (WAIT_W > TRI_W) ? WAIT_W : TRI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [22:0]       req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  input  logic              req_write,
  input  logic [CFG_W-1:0]  req_cfg,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [15:0]       addr_lo,
  output logic [6:0]        addr_hi,
  output logic [15:0]       ad_out,
  output logic              ad_oe,
  input  logic [15:0]       ad_in,
  input  logic              ext_ready
);
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_DLY, S_STB, S_TRI} st_t;

  st_t              st;
  logic [22:0]      a_q;
  logic [15:0]      wd_q, rd_q;
  logic [CFG_W-1:0] c_q;
  logic [CW-1:0]    cnt;
  logic             wr_q, hi_q, two_q, rsp_q;

  wire              mux    = c_q[0];
  wire              bus8   = c_q[1];
  wire [1:0]        asel   = c_q[3:2];
  wire              along  = c_q[4];
  wire              sdel   = c_q[5];
  wire              rdy_en = c_q[6];
  wire [WAIT_W-1:0] waits  = c_q[7 +: WAIT_W];
  wire [TRI_W-1:0]  trs    = c_q[7 + WAIT_W +: TRI_W];

  wire [22:0] cur_a = bus8 ? {a_q[22:1], hi_q} : a_q;
  wire [6:0]  hmask = (asel == 2'd0) ? 7'h00 :
                      (asel == 2'd1) ? 7'h03 :
                      (asel == 2'd2) ? 7'h0F : 7'h7F;
  wire        busy   = (st != S_IDLE);
  wire        strobe = (st == S_STB);
  wire        dphase = (st == S_DLY) || strobe;
  wire [15:0] wbyte  = hi_q ? {8'h00, wd_q[15:8]} : {8'h00, wd_q[7:0]};

  assign req_ready = ~busy;
  assign rsp_valid = rsp_q;
  assign rsp_rdata = rd_q;
  assign ale       = (st == S_ADDR);
  assign rd_n      = ~(strobe & ~wr_q);
  assign wr_n      = ~(strobe & wr_q);
  assign addr_hi   = busy ? (cur_a[22:16] & hmask) : 7'h00;
  assign addr_lo   = (busy && !mux) ? cur_a[15:0] : 16'h0000;
  assign ad_oe     = (ale && mux) || (dphase && wr_q);
  assign ad_out    = (ale && mux)      ? cur_a[15:0] :
                     (dphase && wr_q)  ? (bus8 ? wbyte : wd_q) : 16'h0000;

  wire lo_en = req_be[0] | ~req_be[1];
  wire both  = (req_be[0] == req_be[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      a_q   <= '0;
      wd_q  <= '0;
      rd_q  <= '0;
      c_q   <= '0;
      cnt   <= '0;
      wr_q  <= 1'b0;
      hi_q  <= 1'b0;
      two_q <= 1'b0;
      rsp_q <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q   <= req_addr;
          wd_q  <= req_wdata;
          c_q   <= req_cfg;
          wr_q  <= req_write;
          rd_q  <= '0;
          hi_q  <= req_cfg[1] & ~lo_en;
          two_q <= req_cfg[1] & both;
          cnt   <= CW'(req_cfg[4]);
          st    <= S_ADDR;
        end
        S_ADDR: begin
          if (cnt != '0) cnt <= cnt - ONE;
          else if (sdel) st <= S_DLY;
          else begin
            st  <= S_STB;
            cnt <= CW'(waits);
          end
        end
        S_DLY: begin
          st  <= S_STB;
          cnt <= CW'(waits);
        end
        S_STB: begin
          if (cnt != '0) cnt <= cnt - ONE;
          else if (!rdy_en || ext_ready) begin
            if (!wr_q) begin
              if (!bus8)     rd_q       <= ad_in;
              else if (hi_q) rd_q[15:8] <= ad_in[7:0];
              else           rd_q[7:0]  <= ad_in[7:0];
            end
            if (!wr_q && trs != '0) begin
              st  <= S_TRI;
              cnt <= CW'(trs) - ONE;
            end else if (two_q) begin
              two_q <= 1'b0;
              hi_q  <= 1'b1;
              cnt   <= CW'(along);
              st    <= S_ADDR;
            end else begin
              st    <= S_IDLE;
              rsp_q <= 1'b1;
            end
          end
        end
        S_TRI: begin
          if (cnt != '0) cnt <= cnt - ONE;
          else if (two_q) begin
            two_q <= 1'b0;
            hi_q  <= 1'b1;
            cnt   <= CW'(along);
            st    <= S_ADDR;
          end else begin
            st    <= S_IDLE;
            rsp_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_cycler_chk.sv
module ext_bus_cycler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        ad_oe,
  input logic [15:0] ad_out
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (!ale && rd_n && wr_n && !ad_oe)); // R1
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R1
  AST_ALE_MAX2: assert property (@(posedge clk) disable iff (!rst_n) (ale && $past(ale)) |=> !ale); // R5
  AST_ALE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n) ale |-> (rd_n && wr_n)); // R6
  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!rd_n && !wr_n)); // R12
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R12
  AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !$past(wr_n)) |-> $stable(ad_out)); // R12
endmodule

bind ext_bus_cycler ext_bus_cycler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe), .ad_out(ad_out)
);

// File: tb/ext_bus_cycler_bench.sv
`timescale 1ns/1ps
module ext_bus_cycler_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [22:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [12:0] req_cfg = '0;
  logic        req_ready, rsp_valid, ale, rd_n, wr_n, ad_oe;
  logic [15:0] rsp_rdata, addr_lo, ad_out, ad_in;
  logic [6:0]  addr_hi;
  logic        ext_ready = 1'b0;

  always #2 clk = ~clk;

  int nchk = 0, nerr = 0;
  logic        mon_on = 1'b0, ale_prev = 1'b0, bus_bad = 1'b0;
  logic        cur_mux = 1'b0, cur_bus8 = 1'b0, rdy_on = 1'b0;
  logic [15:0] cur_wd = '0;
  logic [22:0] dev_a = '0;
  logic [22:0] caps [2];
  int          n_ale = 0, n_stb = 0, n_edge = 0, sk = 0;

  function automatic logic [7:0] f8(input logic [22:0] a);
    return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'h3C;
  endfunction

  assign ad_in = cur_bus8 ? {8'hEE, f8(dev_a)}
                          : {f8({dev_a[22:1], 1'b1}), f8({dev_a[22:1], 1'b0})};

  ext_bus_cycler u_ext_bus_cycler (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_write(req_write),
    .req_cfg(req_cfg), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .addr_lo(addr_lo), .addr_hi(addr_hi), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .ext_ready(ext_ready)
  );

  always @(negedge clk) begin
    if (!rd_n || !wr_n) begin
      ext_ready = rdy_on && (sk >= 3);
      sk++;
    end else begin
      sk = 0;
      ext_ready = 1'b0;
    end
  end

  always @(negedge clk) if (mon_on) begin
    logic [15:0] ew;
    if (ale) begin
      if (!ale_prev) begin
        dev_a = {addr_hi, cur_mux ? ad_out : addr_lo};
        if (n_edge < 2) caps[n_edge] = dev_a;
        n_edge++;
      end
      if (cur_mux && !ad_oe) bus_bad = 1'b1;
      if (!cur_mux && addr_lo != dev_a[15:0]) bus_bad = 1'b1;
      n_ale++;
    end
    if (!rd_n || !wr_n) begin
      n_stb++;
      if (!cur_mux && addr_lo != dev_a[15:0]) bus_bad = 1'b1;
      if (!wr_n) begin
        ew = cur_bus8 ? {8'h00, dev_a[0] ? cur_wd[15:8] : cur_wd[7:0]} : cur_wd;
        if (!ad_oe || ad_out != ew) bus_bad = 1'b1;
      end else if (ad_oe) bus_bad = 1'b1;
    end
    ale_prev = ale;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic run(input logic mux, input logic bus8, input logic [1:0] asel,
                     input logic al, input logic sd, input logic [3:0] w,
                     input logic [1:0] tr, input logic rdy, input logic wr,
                     input logic [1:0] be, input logic [22:0] a, input logic [15:0] wd);
    int hold, sl, L, nb, n;
    logic [6:0]  mask;
    logic [22:0] base;
    logic [22:0] ea [2];
    logic [15:0] er;
    hold = rdy ? 3 : 0;
    sl   = ((int'(w) > hold) ? int'(w) : hold) + 1;
    L    = 1 + int'(al) + int'(sd) + sl + (wr ? 0 : int'(tr));
    mask = (asel == 0) ? 7'h00 : (asel == 1) ? 7'h03 : (asel == 2) ? 7'h0F : 7'h7F;
    base = {a[22:16] & mask, a[15:0]};
    er   = 16'h0000;
    if (!bus8) begin
      nb = 1; ea[0] = base; ea[1] = base;
      er = {f8({base[22:1], 1'b1}), f8({base[22:1], 1'b0})};
    end else if (be == 2'b01) begin
      nb = 1; ea[0] = {base[22:1], 1'b0}; ea[1] = ea[0];
      er[7:0] = f8(ea[0]);
    end else if (be == 2'b10) begin
      nb = 1; ea[0] = {base[22:1], 1'b1}; ea[1] = ea[0];
      er[15:8] = f8(ea[0]);
    end else begin
      nb = 2; ea[0] = {base[22:1], 1'b0}; ea[1] = {base[22:1], 1'b1};
      er = {f8(ea[1]), f8(ea[0])};
    end
    @(negedge clk);
    cur_mux = mux; cur_bus8 = bus8; cur_wd = wd; rdy_on = rdy;
    n_ale = 0; n_stb = 0; n_edge = 0; bus_bad = 1'b0; ale_prev = 1'b0;
    req_addr = a; req_wdata = wd; req_be = be; req_write = wr;
    req_cfg = {tr, w, rdy, sd, al, asel, bus8, mux};
    req_valid = 1'b1;
    mon_on = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready while busy", int'(req_ready), 0);
    n = 0;
    while (!rsp_valid && n < 300) begin
      @(negedge clk);
      n++;
    end
    mon_on = 1'b0;
    chk(n == nb * L, "R6 R9 latency", n, nb * L);
    chk(n_ale == nb * (1 + int'(al)), "R5 ale clocks", n_ale, nb * (1 + int'(al)));
    chk(n_stb == nb * sl, rdy ? "R8 strobe clocks" : "R7 strobe clocks", n_stb, nb * sl);
    chk(n_edge == nb, "R10 byte cycles", n_edge, nb);
    for (int i = 0; i < 2; i++)
      if (i < nb) chk(caps[i] == ea[i], "R2 R4 R10 address", int'(caps[i]), int'(ea[i]));
    if (!wr) chk(rsp_rdata == er, "R3 R11 read data", int'(rsp_rdata), int'(er));
    chk(!bus_bad, "R3 R12 bus drive", int'(bus_bad), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int k;
    k = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && !ale && rd_n && wr_n && !ad_oe,
        "R1 reset state", {req_ready, rsp_valid, ale, rd_n, wr_n, ad_oe}, 6'b100110);
    rst_n = 1'b1;
    for (int m = 0; m < 2; m++)
      for (int b8 = 0; b8 < 2; b8++)
        for (int as = 0; as < 4; as++)
          for (int al = 0; al < 2; al++)
            for (int sd = 0; sd < 2; sd++)
              for (int wi = 0; wi < 2; wi++)
                for (int ti = 0; ti < 2; ti++)
                  for (int rd = 0; rd < 2; rd++)
                    for (int wr = 0; wr < 2; wr++)
                      for (int be = 0; be < 4; be++) begin
                        run(1'(m), 1'(b8), 2'(as), 1'(al), 1'(sd), 4'(wi * 2), 2'(ti * 2),
                            1'(rd), 1'(wr), 2'(be), 23'(k * 32'h2F1D3 + 32'h1A5A5),
                            16'((k * 32'h3B7) ^ 32'hA55A));
                        k++;
                      end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule